// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block is a single byte-wide output channel that sits between a processor write strobe and a peripheral that consumes bytes at its own pace. The processor places a byte on the write data bus and pulses an active-low write strobe. When the strobe returns high, the block captures the byte and drives it steadily on the peripheral data lines. It also pulls an active-low buffer-full line low to tell the peripheral that a byte is waiting.

The peripheral takes the byte and answers with an active-low acknowledge pulse. The falling edge of that pulse releases buffer-full. The rising edge of the pulse sets an interrupt request, but only if buffer-full is then inactive, so the processor can supply the next byte. The interrupt output is gated by a mask input. The request is withdrawn as soon as the processor begins its next write, that is, on the falling edge of the write strobe. A one-cycle mode-entry pulse forces buffer-full inactive whenever the surrounding logic switches the channel into a handshaking mode.

Write-strobe edges are detected directly in the clock domain. The acknowledge passes through a configurable synchronizer before its edges are detected, because it comes from outside the processor's timing.

Top module: `strobed_out_port`

## Requirements
- R1: After synchronous reset the port data lines read 0x00, `obf_n` is 1 and `irq` is 0.
- R2: The byte on `wr_data` is captured at the clock edge that first sees `wr_n` high after it was low. From the following cycle it is held on `port_data` until the next such edge.
- R3: `obf_n` goes low in the cycle after the write rising edge is seen.
- R4: A falling edge on `ack_n` drives `obf_n` high. This happens ACK_SYNC+1 clock edges after the change, which is 3 edges at the default setting.
- R5: A rising edge on `ack_n` that arrives while `obf_n` is high sets the interrupt request. `irq` then goes to 1 if `irq_en` is 1.
- R6: While `irq_en` is 0, `irq` stays 0. A pending request is still kept, and it appears on `irq` once `irq_en` returns to 1.
- R7: A falling edge on `wr_n` clears the interrupt request, and `irq` is 0 from the following cycle.
- R8: A second write while `obf_n` is still low replaces the byte on `port_data`, and `obf_n` stays low.
- R9: A `mode_enter` pulse drives `obf_n` high. It wins over a write rising edge in the same cycle, although the byte of that write is still captured.
- R10: A rising edge on `ack_n` while `obf_n` is low neither raises the interrupt nor releases `obf_n`. This case arises when a write completes while the acknowledge is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| wr_data | input | DATA_W | Byte from the processor, valid while `wr_n` is low and on its rising edge |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| irq_en | input | 1 | Interrupt mask, 1 enables `irq` |
| mode_enter | input | 1 | One-cycle pulse on entry into a handshaking mode |
| port_data | output | DATA_W | Latched byte presented to the peripheral |
| obf_n | output | 1 | Output buffer full, active low |
| irq | output | 1 | Interrupt request to the processor, active high |

## Verification
The assertions take for granted that `wr_n` changes at most once per clock and is already synchronous to `clk`. They also take for granted that `wr_data` is steady at the edge where the write rising edge is seen. Each `ack_n` level is assumed to last longer than the synchronizer depth, so that no acknowledge pulse is swallowed between samples. The bench drives every input on the falling clock edge and holds each strobe level for at least two cycles. It keeps every acknowledge level for four cycles, which is longer than the ACK_SYNC+1 edge latency.

// File: rtl/ohp_pkg.sv
// Package: shared types for the strobed output handshake port.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package ohp_pkg;

    // Edge events detected on one strobe line, both one-cycle wide.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

endpackage

// File: rtl/ohp_edge_detect.sv
// Module: ohp_edge_detect
// Purpose: optional synchronizer chain followed by rise/fall detection.
// Assumes: STAGES == 0 means the input is already synchronous to clk;
//          IDLE is the level the line rests at, loaded on reset so no
//          false edge is reported right after reset.
module ohp_edge_detect
    import ohp_pkg::*;
#(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sig_in,
    output edge_ev_t ev
);

    logic level;
    logic prev_q;

    generate
        if (STAGES == 0) begin : g_direct
            // Input already in the clock domain: use it as is.
            assign level = sig_in;
        end else begin : g_sync
            logic [STAGES-1:0] sync_q;
            // Shift the asynchronous input through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= {STAGES{IDLE}};
                else        sync_q <= {sync_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], sig_in};
            end
            assign level = sync_q[STAGES-1];
        end
    endgenerate

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= level;
    end

    // Edge events from current versus previous level.
    always_comb begin
        ev.rise = level & ~prev_q;
        ev.fall = ~level & prev_q;
    end

endmodule

// File: rtl/ohp_data_latch.sv
// Module: ohp_data_latch
// Purpose: holds the byte presented to the peripheral.
// Assumes: load is a single-cycle event; din is steady in that cycle.
module ohp_data_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // Capture on load, otherwise hold; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

endmodule

// File: rtl/ohp_handshake.sv
// Module: ohp_handshake
// Purpose: buffer-full and interrupt-request flags driven by write and
//          acknowledge edge events.
// Assumes: edge events are one-cycle pulses; mode_enter is a one-cycle
//          pulse. Priorities: mode entry over write for buffer-full, write
//          over acknowledge; write fall over acknowledge rise for request.
module ohp_handshake
    import ohp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  edge_ev_t wr_ev,
    input  edge_ev_t ack_ev,
    input  logic     mode_enter,
    output logic     obf,
    output logic     irq_pend
);

    // Buffer-full flag: set by a completed write, cleared by acknowledge or mode entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          obf <= 1'b0;
        else if (mode_enter) obf <= 1'b0;
        else if (wr_ev.rise) obf <= 1'b1;
        else if (ack_ev.fall) obf <= 1'b0;
    end

    // Request flag: set when acknowledge ends with buffer empty, cleared by a new write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     irq_pend <= 1'b0;
        else if (wr_ev.fall)            irq_pend <= 1'b0;
        else if (ack_ev.rise && !obf)   irq_pend <= 1'b1;
    end

    a_r3_obf_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev.rise && !mode_enter) |=> obf);

    a_r4_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ev.fall && !wr_ev.rise && !mode_enter) |=> !obf);

    a_r7_write_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ev.fall |=> !irq_pend);

    a_r9_mode_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mode_enter |=> !obf);

    a_r10_no_req_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ev.rise && obf && !irq_pend) |=> !irq_pend);

endmodule

// File: rtl/strobed_out_port.sv
// Module: strobed_out_port (top)
// Purpose: byte-wide latched output channel with buffer-full/acknowledge
//          handshake and a maskable next-byte interrupt.
// Assumes: wr_n is synchronous to clk; ack_n may be asynchronous and is
//          synchronized over ACK_SYNC flops; reset is synchronous, active low.
module strobed_out_port
    import ohp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ACK_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_n,
    input  logic              irq_en,
    input  logic              mode_enter,
    output logic [DATA_W-1:0] port_data,
    output logic              obf_n,
    output logic              irq
);

    edge_ev_t wr_ev;
    edge_ev_t ack_ev;
    logic     obf;
    logic     irq_pend;

    ohp_edge_detect #(.STAGES(0), .IDLE(1'b1)) u_wr_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (wr_n),
        .ev     (wr_ev)
    );

    ohp_edge_detect #(.STAGES(ACK_SYNC), .IDLE(1'b1)) u_ack_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (ack_n),
        .ev     (ack_ev)
    );

    ohp_data_latch #(.W(DATA_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_ev.rise),
        .din   (wr_data),
        .dout  (port_data)
    );

    ohp_handshake u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ev      (wr_ev),
        .ack_ev     (ack_ev),
        .mode_enter (mode_enter),
        .obf        (obf),
        .irq_pend   (irq_pend)
    );

    // Drive the active-low buffer-full line and the masked request.
    always_comb begin
        obf_n = ~obf;
        irq   = irq_pend & irq_en;
    end

    a_r2_byte_captured: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ev.rise |=> (port_data == $past(wr_data)));

    a_r2_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ev.rise |=> $stable(port_data));

endmodule

// File: tb/strobed_out_port_tb.sv
module strobed_out_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1;
    logic [7:0] wr_data = 8'h00;
    logic       ack_n = 1'b1;
    logic       irq_en = 1'b0;
    logic       mode_enter = 1'b0;
    logic [7:0] port_data;
    logic       obf_n;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    strobed_out_port u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_n       (wr_n),
        .wr_data    (wr_data),
        .ack_n      (ack_n),
        .irq_en     (irq_en),
        .mode_enter (mode_enter),
        .port_data  (port_data),
        .obf_n      (obf_n),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Full write cycle: strobe low two cycles, then high; returns one cycle after the rise is seen.
    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_n = 1'b0; wr_data = d;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ack_level(input logic v);
        @(negedge clk);
        ack_n = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 port_data", port_data, 8'h00);
        chk("R1 obf_n", {7'd0, obf_n}, 8'd1);
        chk("R1 irq", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_basic;
        irq_en = 1'b1;
        write_byte(8'hA5);
        chk("R2 captured", port_data, 8'hA5);
        chk("R3 obf_n low", {7'd0, obf_n}, 8'd0);
        chk("R3 no irq yet", {7'd0, irq}, 8'd0);
        @(negedge clk);
        ack_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 obf_n before latency", {7'd0, obf_n}, 8'd0);
        repeat (2) @(negedge clk);
        chk("R4 obf_n released", {7'd0, obf_n}, 8'd1);
        chk("R5 irq not before ack rise", {7'd0, irq}, 8'd0);
        ack_level(1'b1);
        chk("R5 irq raised", {7'd0, irq}, 8'd1);
        chk("R2 byte held", port_data, 8'hA5);
        @(negedge clk);
        wr_n = 1'b0; wr_data = 8'h3C;
        @(negedge clk);
        chk("R7 irq cleared on wr fall", {7'd0, irq}, 8'd0);
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        chk("R2 second byte", port_data, 8'h3C);
        ack_level(1'b0);
        ack_level(1'b1);
    endtask

    task automatic t_mask;
        irq_en = 1'b0;
        write_byte(8'h5A);
        ack_level(1'b0);
        ack_level(1'b1);
        chk("R6 irq masked", {7'd0, irq}, 8'd0);
        irq_en = 1'b1;
        #1;
        chk("R6 pending shown on unmask", {7'd0, irq}, 8'd1);
    endtask

    task automatic t_overwrite;
        write_byte(8'h11);
        write_byte(8'h22);
        chk("R8 replaced byte", port_data, 8'h22);
        chk("R8 obf_n stays low", {7'd0, obf_n}, 8'd0);
        ack_level(1'b0);
        ack_level(1'b1);
    endtask

    task automatic t_mode;
        write_byte(8'h77);
        chk("R9 obf_n low before mode", {7'd0, obf_n}, 8'd0);
        @(negedge clk);
        mode_enter = 1'b1;
        @(negedge clk);
        mode_enter = 1'b0;
        chk("R9 mode forces obf_n high", {7'd0, obf_n}, 8'd1);
        chk("R9 byte kept", port_data, 8'h77);
        @(negedge clk);
        wr_n = 1'b0; wr_data = 8'h99;
        repeat (2) @(negedge clk);
        wr_n = 1'b1; mode_enter = 1'b1;
        @(negedge clk);
        mode_enter = 1'b0;
        chk("R9 mode beats write", {7'd0, obf_n}, 8'd1);
        chk("R9 write byte captured", port_data, 8'h99);
    endtask

    task automatic t_write_during_ack;
        ack_level(1'b0);
        write_byte(8'hC3);
        chk("R10 obf_n low under ack", {7'd0, obf_n}, 8'd0);
        chk("R10 request cleared", {7'd0, irq}, 8'd0);
        ack_level(1'b1);
        chk("R10 no irq while full", {7'd0, irq}, 8'd0);
        chk("R10 obf_n still low", {7'd0, obf_n}, 8'd0);
        ack_level(1'b0);
        chk("R4 released by next ack", {7'd0, obf_n}, 8'd1);
        ack_level(1'b1);
        chk("R5 irq after full exchange", {7'd0, irq}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_mask();
        t_overwrite();
        t_mode();
        t_write_during_ack();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule